// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a cycle-level, synthesizable model of a synchronous static RAM with flow-through reads and short bursts. Each word is 36 bits wide and is split into four 9-bit byte lanes: 8 data bits and 1 parity bit per lane. All control, address and write-data inputs are taken at the rising clock edge. Read data for the address taken at an edge appears in the cycle that follows that edge. There is no output register stage in the read path.

An access begins when one of two address strobes is low. One strobe always starts a read. The other starts a read or a write, depending on the write controls. After the start, an internal 2-bit counter steps through the four words of an aligned group, either in linear or in interleaved (XOR) order. An advance input steps the counter; while advance is inactive the address is held. Three chip selects, sampled only with a strobe, decide whether the device takes part. An output-enable input gates the read data combinationally. A doze input puts the array into a data-retaining sleep after two edges and wakes it two edges after release. Pad behaviour is modelled by a valid flag, `rvalid`, in place of high impedance.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset the block is deselected. `rvalid` is 0. A cycle with both strobes high and advance active does nothing until a burst has been started.
- R2: When a strobe starts a cycle, the cycle is a deselect if `sel_a_n` is high, `sel_b` is low or `sel_c_n` is high. A deselect makes `rvalid` 0 after that edge and writes nothing. While `sel_a_n` is high, `start_cpu_n` is ignored.
- R3: A cycle started by `start_cpu_n` low (with `sel_a_n` low and the other selects valid) is a read, whatever the write controls are. A write on the next cycle with advance inactive goes to that same address.
- R4: A cycle started by `start_ctl_n` low (with `start_cpu_n` high) reads or writes according to the write decode. Read data for the address taken at an edge is on `rdata` right after that edge.
- R5: With `wr_all_n` low, all 36 bits are written, whatever `wr_byte_n` and `lane_wr_n` are.
- R6: With `wr_all_n` high and `wr_byte_n` low, a lane is written for each `lane_wr_n` bit that is low. Bit 0 selects bits [8:0], bit 1 selects [17:9], bit 2 selects [26:18] and bit 3 selects [35:27].
- R7: The cycle is a read when `wr_all_n` and `wr_byte_n` are both high, or when `wr_byte_n` is low but every `lane_wr_n` bit is high.
- R8: With `burst_ilv` low, each advance adds 1 to the two low address bits modulo 4, starting from the base address. The upper bits stay unchanged, so the fourth advance wraps back to the base.
- R9: With `burst_ilv` high, the k-th word of a burst has low bits equal to the base low bits XOR k, and the upper bits stay unchanged.
- R10: A continue cycle with `adv_n` high, and both strobes high, keeps the current address for a read or a write.
- R11: `rvalid` is 1 only after a read cycle and only while `oe_n` is low. It follows `oe_n` in the same cycle and is 0 after any write cycle.
- R12: `doze` held high for 2 edges puts the block to sleep, and held low for 2 edges wakes it. Accesses at the two entry edges still take effect. While asleep, and at the two wake edges, all other inputs are ignored and `rvalid` is 0. Memory contents are kept. The block wakes deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are taken at its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW (6) | Word address, taken only with a strobe |
| start_cpu_n | input | 1 | Strobe that always starts a read (active low) |
| start_ctl_n | input | 1 | Strobe that starts a read or a write (active low) |
| adv_n | input | 1 | Burst advance (active low) |
| sel_a_n | input | 1 | Chip select, active low; also masks `start_cpu_n` |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write of all lanes (active low) |
| wr_byte_n | input | 1 | Enable for the per-lane writes (active low) |
| lane_wr_n | input | 4 | Per-lane write selects (active low) |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable (active low, combinational) |
| doze | input | 1 | Sleep request |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
A wrong burst counter or base register shows up on the first read after the faulty advance. It appears as the wrong word on `rdata`, one edge after that advance, because there is no output stage to hide it. A bad write decode only shows when the address is read back, so each lane pattern is followed at once by a read of the same word. A sleep state that flips on the wrong edge shows as `rvalid` staying high, or going low one cycle early or late, around the doze edges. A lost or spurious burst-active state shows as `rvalid` at the first continue cycle.

// File: rtl/fts_pkg.sv
// Package: shared cycle type and burst-order helpers for the flow-through
// burst SRAM. Assumes a burst always covers the four words of an aligned group.
package fts_pkg;

    // Bits of the address that the burst counter walks.
    localparam int BURST_W = 2;

    // Kind of cycle decided at one clock edge.
    typedef enum logic [2:0] {
        CY_IDLE,
        CY_DESEL,
        CY_BEGIN_RD,
        CY_BEGIN_WR,
        CY_CONT_RD,
        CY_CONT_WR,
        CY_SUSP_RD,
        CY_SUSP_WR
    } cyc_e;

    // Low address bits of the burst word at position cnt.
    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

    // True for any cycle that writes the array.
    function automatic logic is_write(input cyc_e c);
        return (c == CY_BEGIN_WR) || (c == CY_CONT_WR) || (c == CY_SUSP_WR);
    endfunction

endpackage

// File: rtl/fts_cyc_decode.sv
// Cycle decoder: turns the strobes, selects, advance and write controls of one
// edge into a cycle kind and a lane write mask.
// Assumes: burst_on tells whether a burst is open; asleep blocks every access.
module fts_cyc_decode
    import fts_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             start_cpu_n,
    input  logic             start_ctl_n,
    input  logic             adv_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             burst_on,
    input  logic             asleep,
    output cyc_e             cyc,
    output logic [LANES-1:0] lane_en
);

    logic chip_ok;
    logic wr_req;

    assign chip_ok = !sel_a_n && sel_b && !sel_c_n;

    // Layered write priority: write-all first, then per-lane selects.
    always_comb begin : p_write_decode
        if (!wr_all_n) begin
            lane_en = '1;
        end else if (!wr_byte_n) begin
            lane_en = ~lane_wr_n;
        end else begin
            lane_en = '0;
        end
        wr_req = |lane_en;
    end

    // Cycle kind; the read-only strobe wins and is masked by sel_a_n.
    always_comb begin : p_cycle
        if (asleep) begin
            cyc = CY_IDLE;
        end else if (!start_cpu_n && !sel_a_n) begin
            cyc = chip_ok ? CY_BEGIN_RD : CY_DESEL;
        end else if (!start_ctl_n) begin
            if (!chip_ok) begin
                cyc = CY_DESEL;
            end else begin
                cyc = wr_req ? CY_BEGIN_WR : CY_BEGIN_RD;
            end
        end else if (!burst_on) begin
            cyc = CY_IDLE;
        end else if (!adv_n) begin
            cyc = wr_req ? CY_CONT_WR : CY_CONT_RD;
        end else begin
            cyc = wr_req ? CY_SUSP_WR : CY_SUSP_RD;
        end
    end

endmodule

// File: rtl/fts_burst_seq.sv
// Burst address sequencer: keeps the upper address bits, the base low bits
// and a 2-bit position counter. It gives the current address and the address
// that an access at this edge uses.
// Assumes AW > BURST_W and that burst_ilv changes only between bursts.
module fts_burst_seq
    import fts_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          ilv,
    input  logic [AW-1:0] ld_addr,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] acc_addr
);

    localparam int HW = AW - BURST_W;

    logic [HW-1:0]      hi_q;
    logic [BURST_W-1:0] base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;

    assign cnt_nx   = cnt_q + BURST_W'(1);
    assign cur_addr = {hi_q, burst_lo(base_q, cnt_q, ilv)};

    // Address used by an access at this edge.
    always_comb begin : p_access_addr
        if (load) begin
            acc_addr = ld_addr;
        end else if (step) begin
            acc_addr = {hi_q, burst_lo(base_q, cnt_nx, ilv)};
        end else begin
            acc_addr = cur_addr;
        end
    end

    // Base capture on a burst start, counter step on an advance.
    always_ff @(posedge clk) begin : p_seq_regs
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            hi_q   <= ld_addr[AW-1:BURST_W];
            base_q <= ld_addr[BURST_W-1:0];
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end

endmodule

// File: rtl/fts_lane_array.sv
// Storage array split into independent byte lanes, one generated array per
// lane. Writes at the clock edge; reads combinationally (flow-through).
// Assumes: no reset, so contents are kept across sleep.
module fts_lane_array #(
    parameter int DEPTH  = 64,
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] lane_en,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Lane write when the cycle writes and this lane is selected.
        always_ff @(posedge clk) begin : p_lane_wr
            if (we && lane_en[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/fts_doze_ctl.sv
// Sleep controller: the sleep state follows the doze request only after the
// request has differed from it for LAT consecutive edges.
// Assumes LAT >= 1.
module fts_doze_ctl #(
    parameter int LAT = 2,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic doze,
    output logic asleep
);

    logic [CW-1:0] run_q;

    // Count edges of disagreement, flip after LAT of them.
    always_ff @(posedge clk) begin : p_doze
        if (!rst_n) begin
            asleep <= 1'b0;
            run_q  <= '0;
        end else if (doze != asleep) begin
            if (run_q == CW'(LAT - 1)) begin
                asleep <= doze;
                run_q  <= '0;
            end else begin
                run_q  <= run_q + CW'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

endmodule

// File: rtl/fts_burst_sram.sv
// Top of the flow-through synchronous burst SRAM model. It ties together the
// cycle decoder, the burst sequencer, the lane array and the sleep controller,
// and holds the burst-open and read-cycle state.
// Assumes: high impedance is modelled by rvalid = 0 with rdata = 0.
module fts_burst_sram
    import fts_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int DOZE_LAT = 2,
    localparam int AW      = $clog2(DEPTH),
    localparam int DW      = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             start_cpu_n,
    input  logic             start_ctl_n,
    input  logic             adv_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             burst_ilv,
    input  logic             oe_n,
    input  logic             doze,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);

    cyc_e             cyc;
    logic [LANES-1:0] lane_en;
    logic             asleep;
    logic             sel_q;
    logic             rd_q;
    logic             load;
    logic             step;
    logic             we;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    acc_addr;
    logic [DW-1:0]    arr_rd;

    fts_doze_ctl #(
        .LAT (DOZE_LAT)
    ) i_doze (
        .clk    (clk),
        .rst_n  (rst_n),
        .doze   (doze),
        .asleep (asleep)
    );

    fts_cyc_decode #(
        .LANES (LANES)
    ) i_decode (
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .adv_n       (adv_n),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .wr_all_n    (wr_all_n),
        .wr_byte_n   (wr_byte_n),
        .lane_wr_n   (lane_wr_n),
        .burst_on    (sel_q),
        .asleep      (asleep),
        .cyc         (cyc),
        .lane_en     (lane_en)
    );

    assign load = (cyc == CY_BEGIN_RD) || (cyc == CY_BEGIN_WR);
    assign step = (cyc == CY_CONT_RD) || (cyc == CY_CONT_WR);
    assign we   = is_write(cyc);

    fts_burst_seq #(
        .AW (AW)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .ilv      (burst_ilv),
        .ld_addr  (addr_i),
        .cur_addr (cur_addr),
        .acc_addr (acc_addr)
    );

    fts_lane_array #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_array (
        .clk     (clk),
        .we      (we),
        .lane_en (lane_en),
        .waddr   (acc_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (arr_rd)
    );

    // Burst-open and read-cycle flags; sleep closes any open burst.
    always_ff @(posedge clk) begin : p_burst_state
        if (!rst_n) begin
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
        end else if (asleep) begin
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            case (cyc)
                CY_IDLE: begin
                    sel_q <= sel_q;
                    rd_q  <= rd_q;
                end
                CY_DESEL: begin
                    sel_q <= 1'b0;
                    rd_q  <= 1'b0;
                end
                CY_BEGIN_RD, CY_CONT_RD, CY_SUSP_RD: begin
                    sel_q <= 1'b1;
                    rd_q  <= 1'b1;
                end
                default: begin
                    sel_q <= 1'b1;
                    rd_q  <= 1'b0;
                end
            endcase
        end
    end

    // Output gating: read cycle, output enabled, not asleep.
    always_comb begin : p_out
        rvalid = rd_q && !oe_n && !asleep;
        rdata  = rvalid ? arr_rd : '0;
    end

endmodule

// File: rtl/fts_sram_chk.sv
// Checker for fts_burst_sram: temporal properties on the ports, the decoded
// cycle, the sleep state and the sequencer address. Attached by bind below.
module fts_sram_chk
    import fts_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_cpu_n,
    input logic          start_ctl_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          oe_n,
    input logic          burst_ilv,
    input logic          rvalid,
    input logic          asleep,
    input cyc_e          cyc,
    input logic [AW-1:0] cur_addr
);

    assert_valid_needs_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !oe_n);

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_write(cyc))) |-> !rvalid);

    assert_quiet_asleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !rvalid);

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!start_ctl_n || (!start_cpu_n && !sel_a_n))
         && (sel_a_n || !sel_b || sel_c_n) && !asleep) |=> !rvalid);

    assert_cpu_start_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n)
         && $past(!start_cpu_n && !sel_a_n && sel_b && !sel_c_n && !asleep)
         && !oe_n && !asleep) |-> rvalid);

    assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((cyc == CY_CONT_RD) || (cyc == CY_CONT_WR))
         && !burst_ilv && !$past(burst_ilv))
        |-> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    assert_upper_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((cyc == CY_CONT_RD) || (cyc == CY_CONT_WR)))
        |-> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    assert_suspend_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((cyc == CY_SUSP_RD) || (cyc == CY_SUSP_WR))
         && $stable(burst_ilv))
        |-> (cur_addr == $past(cur_addr)));

endmodule

bind fts_burst_sram fts_sram_chk #(
    .AW (AW)
) i_fts_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .oe_n        (oe_n),
    .burst_ilv   (burst_ilv),
    .rvalid      (rvalid),
    .asleep      (asleep),
    .cyc         (cyc),
    .cur_addr    (cur_addr)
);

// File: tb/test_fts_burst_sram.sv
// Bench for fts_burst_sram: a vector table walked by one loop, then directed
// tests for reset, chip selects, strobe masking, interleaved order and sleep.
module test_fts_burst_sram;

    localparam int PER = 10;
    localparam int AW  = 6;
    localparam int DW  = 36;

    // Control word: {start_cpu_n, start_ctl_n, adv_n, wr_all_n, wr_byte_n, lane_wr_n[3:0], oe_n}
    localparam logic [9:0] C_IDLE    = 10'b1_1_1_1_1_1111_0;
    localparam logic [9:0] C_WR_G    = 10'b1_0_1_0_1_1111_0;
    localparam logic [9:0] C_RD      = 10'b1_0_1_1_1_1111_0;
    localparam logic [9:0] C_CONT_WR = 10'b1_1_0_0_1_1111_0;
    localparam logic [9:0] C_CONT_RD = 10'b1_1_0_1_1_1111_0;
    localparam logic [9:0] C_SUSP_RD = 10'b1_1_1_1_1_1111_0;
    localparam logic [9:0] C_SUSP_OFF= 10'b1_1_1_1_1_1111_1;
    localparam logic [9:0] C_CPU_WR  = 10'b0_1_1_0_0_0000_0;
    localparam logic [9:0] C_SUSP_WR = 10'b1_1_1_0_1_1111_0;

    // Row: {req(4), ctl(10), addr(6), wdata(36), exp_valid(1), exp_data(36)}
    localparam int NV = 27;
    localparam logic [92:0] VEC [NV] = '{
        {4'd5,  C_WR_G,    6'd4,  36'h123456789, 1'b0, 36'h0},          // R5 write base
        {4'd8,  C_CONT_WR, 6'd0,  36'h2468ACE13, 1'b0, 36'h0},          // R8 -> 5
        {4'd8,  C_CONT_WR, 6'd0,  36'h0F0F0F0F0, 1'b0, 36'h0},          // R8 -> 6
        {4'd8,  C_CONT_WR, 6'd0,  36'hFEDCBA987, 1'b0, 36'h0},          // R8 -> 7
        {4'd8,  C_CONT_WR, 6'd0,  36'h111111111, 1'b0, 36'h0},          // R8 wrap -> 4
        {4'd4,  C_RD,      6'd4,  36'h0,         1'b1, 36'h111111111},  // R4 flow-through
        {4'd8,  C_CONT_RD, 6'd0,  36'h0,         1'b1, 36'h2468ACE13},  // R8
        {4'd10, C_SUSP_RD, 6'd0,  36'h0,         1'b1, 36'h2468ACE13},  // R10 hold
        {4'd11, C_SUSP_OFF,6'd0,  36'h0,         1'b0, 36'h0},          // R11 oe high
        {4'd8,  C_CONT_RD, 6'd0,  36'h0,         1'b1, 36'h0F0F0F0F0},  // R8
        {4'd3,  C_CPU_WR,  6'd7,  36'hFFFFFFFFF, 1'b1, 36'hFEDCBA987},  // R3 forced read
        {4'd8,  C_CONT_RD, 6'd0,  36'h0,         1'b1, 36'h111111111},  // R8 7 -> 4
        {4'd5,  C_WR_G,    6'd10, 36'h0000000AA, 1'b0, 36'h0},          // R5
        {4'd3,  C_CPU_WR,  6'd10, 36'h0,         1'b1, 36'h0000000AA},  // R3
        {4'd3,  C_SUSP_WR, 6'd0,  36'h777777777, 1'b0, 36'h0},          // R3 write after
        {4'd10, C_RD,      6'd10, 36'h0,         1'b1, 36'h777777777},  // R10 same address
        {4'd5,  C_WR_G,    6'd8,  36'h0,         1'b0, 36'h0},          // R5 clear
        {4'd6,  10'b1_0_1_1_0_1110_0, 6'd8, 36'hFFFFFFFFF, 1'b0, 36'h0},// R6 lane bits[8:0]
        {4'd6,  C_RD,      6'd8,  36'h0,         1'b1, 36'h0000001FF},  // R6
        {4'd6,  10'b1_0_1_1_0_0111_0, 6'd8, 36'hABCDEF123, 1'b0, 36'h0},// R6 lane bits[35:27]
        {4'd6,  C_RD,      6'd8,  36'h0,         1'b1, 36'hAB80001FF},  // R6
        {4'd7,  10'b1_0_1_1_0_1111_0, 6'd8, 36'hFFFFFFFFF, 1'b1, 36'hAB80001FF}, // R7
        {4'd7,  10'b1_0_1_1_1_0000_0, 6'd8, 36'hFFFFFFFFF, 1'b1, 36'hAB80001FF}, // R7
        {4'd5,  10'b1_0_1_0_0_1010_0, 6'd9, 36'h5A5A5A5A5, 1'b0, 36'h0},// R5 overrides lanes
        {4'd5,  C_RD,      6'd9,  36'h0,         1'b1, 36'h5A5A5A5A5},  // R5
        {4'd6,  10'b1_0_1_1_0_1001_0, 6'd9, 36'h0, 1'b0, 36'h0},        // R6 lanes [26:9]
        {4'd6,  C_RD,      6'd9,  36'h0,         1'b1, 36'h5A00001A5}   // R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          start_cpu_n = 1'b1;
    logic          start_ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          sel_a_n = 1'b0;
    logic          sel_b = 1'b1;
    logic          sel_c_n = 1'b0;
    logic          wr_all_n = 1'b1;
    logic          wr_byte_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          burst_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic          doze = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    fts_burst_sram i_fts_burst_sram (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .adv_n       (adv_n),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .wr_all_n    (wr_all_n),
        .wr_byte_n   (wr_byte_n),
        .lane_wr_n   (lane_wr_n),
        .burst_ilv   (burst_ilv),
        .oe_n        (oe_n),
        .doze        (doze),
        .wdata       (wdata),
        .rdata       (rdata),
        .rvalid      (rvalid)
    );

    always #(PER/2) clk = ~clk;

    // Compare the outputs with the expected valid flag and, if valid, data.
    task automatic check(input string tag, input logic ev, input logic [DW-1:0] ed);
        n_chk++;
        if (rvalid !== ev || (ev && rdata !== ed)) begin
            n_bad++;
            $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    // Drive one cycle at the falling edge, then sample after the rising edge.
    task automatic apply(input logic [9:0] ctl, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        {start_cpu_n, start_ctl_n, adv_n, wr_all_n, wr_byte_n, lane_wr_n, oe_n} = ctl;
        addr_i = a;
        wdata  = d;
        @(posedge clk);
        #(PER/4);
    endtask

    task automatic step(input string tag, input logic [9:0] ctl, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic ev, input logic [DW-1:0] ed);
        apply(ctl, a, d);
        check(tag, ev, ed);
    endtask

    initial begin : p_watchdog
        #(PER * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : p_main
        repeat (3) @(posedge clk);
        #(PER/4);
        check("R1 valid during reset", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 idle after reset", C_IDLE, 6'd0, '0, 1'b0, '0);
        step("R1 advance without burst", C_CONT_RD, 6'd0, '0, 1'b0, '0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step($sformatf("R%0d row %0d", VEC[i][92:89], i), VEC[i][88:79],
                 VEC[i][78:73], VEC[i][72:37], VEC[i][36], VEC[i][35:0]);
        end

        // R2: each select on its own deselects
        sel_b = 1'b0;
        step("R2 sel_b low read", C_RD, 6'd4, '0, 1'b0, '0);
        step("R2 sel_b low write", C_WR_G, 6'd4, 36'h0, 1'b0, '0);
        sel_b = 1'b1;
        sel_c_n = 1'b1;
        step("R2 sel_c_n high read", C_RD, 6'd4, '0, 1'b0, '0);
        sel_c_n = 1'b0;
        sel_a_n = 1'b1;
        step("R2 sel_a_n high read", C_RD, 6'd4, '0, 1'b0, '0);
        sel_a_n = 1'b0;
        step("R2 deselected write kept data", C_RD, 6'd4, '0, 1'b1, 36'h111111111);

        // R3: read-only strobe masked by sel_a_n acts as an advance
        step("R3 setup read at 5", C_RD, 6'd5, '0, 1'b1, 36'h2468ACE13);
        sel_a_n = 1'b1;
        step("R3 masked strobe advances", 10'b0_1_0_1_1_1111_0, 6'd0, '0, 1'b1, 36'h0F0F0F0F0);
        sel_a_n = 1'b0;

        // R9: interleaved order from base 5: 5, 4, 7, 6
        sel_a_n = 1'b1;
        step("R2 deselect before mode change", C_RD, 6'd0, '0, 1'b0, '0);
        sel_a_n = 1'b0;
        burst_ilv = 1'b1;
        step("R9 base 5", C_RD, 6'd5, '0, 1'b1, 36'h2468ACE13);
        step("R9 second 4", C_CONT_RD, 6'd0, '0, 1'b1, 36'h111111111);
        step("R9 third 7", C_CONT_RD, 6'd0, '0, 1'b1, 36'hFEDCBA987);
        step("R9 fourth 6", C_CONT_RD, 6'd0, '0, 1'b1, 36'h0F0F0F0F0);
        sel_a_n = 1'b1;
        step("R2 deselect after interleave", C_RD, 6'd0, '0, 1'b0, '0);
        sel_a_n = 1'b0;
        burst_ilv = 1'b0;

        // R12: sleep entry, ignored accesses, wake and retention
        step("R12 read before doze", C_RD, 6'd5, '0, 1'b1, 36'h2468ACE13);
        doze = 1'b1;
        step("R12 first entry edge still awake", C_SUSP_RD, 6'd0, '0, 1'b1, 36'h2468ACE13);
        step("R12 asleep after second edge", C_SUSP_RD, 6'd0, '0, 1'b0, '0);
        step("R12 write while asleep", C_WR_G, 6'd5, 36'h0, 1'b0, '0);
        doze = 1'b0;
        step("R12 first wake edge ignored", C_WR_G, 6'd5, 36'h0, 1'b0, '0);
        step("R12 second wake edge ignored", C_WR_G, 6'd5, 36'h0, 1'b0, '0);
        step("R12 wakes deselected", C_CONT_RD, 6'd0, '0, 1'b0, '0);
        step("R12 contents kept", C_RD, 6'd5, '0, 1'b1, 36'h2468ACE13);

        // R11: output enable acts within the cycle
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        check("R11 oe high same cycle", 1'b0, '0);
        oe_n = 1'b0;
        #1;
        check("R11 oe low same cycle", 1'b1, 36'h2468ACE13);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule